// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block sits in the write-clock domain of a synchronous FIFO. It holds the two threshold offsets that the flag logic uses: the almost-empty threshold and the almost-full threshold. Software or a controller loads them through the FIFO's own data input lines. No separate address or register bus is used.

A load occurs when the load control and the write enable (both active low) are low together at a rising write-clock edge. The low bits of the data input are then captured into one offset register. A one-bit sequence pointer selects which register is written. The pointer starts at the empty offset and flips after every load edge, so loads alternate between the two registers and wrap around without limit.

The pointer is not cleared between load sessions. A session that writes only one register therefore leaves the next session to start on the other register. For as long as the load control is low, the block withholds the memory write strobe, so ordinary data writes cannot happen during loading.

Top module: `offset_loader`

## Requirements
- R1: Asynchronous reset (rst_n low) sets both offsets to OFS_RST (default 31) and points the sequence pointer at the empty offset.
- R2: A load edge is a rising wclk edge with load_n = 0 and wr_en_n = 0. The first load edge after reset writes din[OFS_W-1:0] into empty_ofs and leaves full_ofs unchanged.
- R3: A load edge that follows a load into empty_ofs writes din[OFS_W-1:0] into full_ofs and leaves empty_ofs unchanged.
- R4: A load edge that follows a load into full_ofs writes empty_ofs again (wrap-around).
- R5: A rising edge with load_n = 0 and wr_en_n = 1 changes neither offset and does not advance the pointer.
- R6: The pointer position survives load_n going high. A later load session continues with the register after the last one written.
- R7: data_wr is 1 exactly when wr_en_n = 0 and load_n = 1. wr_inhibit is 1 exactly when load_n = 0.
- R8: Data input bits at position OFS_W and above never affect either offset.
- R9: With load_n = 1, both offsets hold their values whatever wr_en_n and din do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Offset load control, active low |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DIN_W | Data input lines |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |
| data_wr | output | 1 | Write strobe to FIFO memory and write pointer |
| wr_inhibit | output | 1 | High while data-path writes are blocked by loading |

## Verification
The bench builds the block with its defaults: an 18-bit data input and 12-bit offsets. This means every load carries bits above the offset field, which are always set to nonzero so that R8 is tested on each load. A directed run covers reset, a full three-edge wrap and a split session. A 1024-cycle sweep then steps through arithmetically mixed combinations of load_n and wr_en_n. Those combinations produce load sessions of one, two and many edges, as well as stalled edges, so both pointer positions are met at every session start. Two resets in the middle of the run confirm that the pointer returns to the empty register.

// File: rtl/offset_loader.sv
module offset_loader #(
  parameter int DIN_W   = 18,
  parameter int OFS_W   = 12,
  parameter int OFS_RST = 31
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             wr_en_n,
  input  logic [DIN_W-1:0] din,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             data_wr,
  output logic             wr_inhibit
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(OFS_RST);

  logic             sel_full;
  logic             load_edge;
  logic [OFS_W-1:0] ofs_in;
  logic             unused_hi;

  assign load_edge  = !load_n && !wr_en_n;
  assign ofs_in     = din[OFS_W-1:0];
  assign unused_hi  = ^din[DIN_W-1:OFS_W];
  assign data_wr    = load_n && !wr_en_n;
  assign wr_inhibit = !load_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      empty_ofs <= RST_VAL;
      full_ofs  <= RST_VAL;
      sel_full  <= 1'b0;
    end else if (load_edge) begin
      if (sel_full) full_ofs  <= ofs_in;
      else          empty_ofs <= ofs_in;
      sel_full <= !sel_full;
    end
  end

  // R2
  empty_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (load_edge && !sel_full) |=> (empty_ofs == $past(ofs_in)) && $stable(full_ofs));

  // R3
  full_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (load_edge && sel_full) |=> (full_ofs == $past(ofs_in)) && $stable(empty_ofs));

  // R4
  ptr_wrap_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    load_edge |=> (sel_full != $past(sel_full)));

  // R5
  stall_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!load_n && wr_en_n) |=> $stable(sel_full) && $stable(empty_ofs) && $stable(full_ofs));

  // R9
  idle_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    load_n |=> $stable(sel_full) && $stable(empty_ofs) && $stable(full_ofs));

  // R7
  no_write_in_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_inhibit |-> !data_wr);
endmodule

// File: tb/offset_loader_test.sv
module offset_loader_test;
  localparam int DIN_W = 18;
  localparam int OFS_W = 12;
  localparam int RSTV  = 31;

  logic             wclk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_n = 1'b1;
  logic             wr_en_n = 1'b1;
  logic [DIN_W-1:0] din = '0;
  logic [OFS_W-1:0] empty_ofs, full_ofs;
  logic             data_wr, wr_inhibit;

  int tests = 0;
  int fails = 0;
  logic             m_ptr;
  logic [OFS_W-1:0] m_e, m_f;
  logic             was_idle;

  offset_loader #(.DIN_W(DIN_W), .OFS_W(OFS_W), .OFS_RST(RSTV)) uut (
    .wclk(wclk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n), .din(din),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .data_wr(data_wr), .wr_inhibit(wr_inhibit));

  always #4 wclk = !wclk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req);
    chk({req, " empty"}, int'(empty_ofs), int'(m_e));
    chk({req, " full"},  int'(full_ofs),  int'(m_f));
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    #1;
    m_e = OFS_W'(RSTV); m_f = OFS_W'(RSTV); m_ptr = 1'b0; was_idle = 1'b1;
    chk_ofs("R1");
    @(negedge wclk);
    rst_n = 1'b1;
  endtask

  // Apply one cycle at negedge; the model captures the effect of the next posedge.
  task automatic step(input logic ld, input logic we, input logic [DIN_W-1:0] d);
    load_n = ld; wr_en_n = we; din = d;
    #1;
    chk("R7 data_wr", int'(data_wr), int'(ld && !we));
    chk("R7 wr_inhibit", int'(wr_inhibit), int'(!ld));
    @(negedge wclk);
    if (!ld && !we) begin
      if (m_ptr) m_f = d[OFS_W-1:0]; else m_e = d[OFS_W-1:0];
      if (was_idle && m_ptr) chk_ofs("R6 resume on full");
      else if (m_ptr) chk_ofs("R3 full load");
      else if (!was_idle) chk_ofs("R4 wrap to empty");
      else chk_ofs("R2 empty load");
      chk_ofs("R8 upper bits");
      m_ptr = !m_ptr;
      was_idle = 1'b0;
    end else if (!ld) begin
      chk_ofs("R5 stalled load");
    end else begin
      was_idle = 1'b1;
      chk_ofs("R9 idle");
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // directed: R2, R3, R4 with upper bits set (R8)
    step(1'b0, 1'b0, 18'h3_0ABC);
    step(1'b0, 1'b0, 18'h2_0123);
    step(1'b0, 1'b0, 18'h1_0FFF);
    step(1'b1, 1'b0, 18'h0_0555);
    // resume on full (R6), stall (R5), resume on empty
    step(1'b0, 1'b0, 18'h3_0777);
    step(1'b0, 1'b1, 18'h0_0111);
    step(1'b1, 1'b1, 18'h0_0222);
    step(1'b0, 1'b0, 18'h2_0999);
    do_reset();
    for (int i = 0; i < 1024; i++) begin
      logic ld, we;
      logic [DIN_W-1:0] d;
      ld = logic'(((i * 7) >> 2) & 1) ^ logic'((i >> 5) & 1);
      we = logic'(i & 1) & logic'((i >> 3) & 1);
      d  = DIN_W'((i * 2654435 + 977) & 32'h3FFFF) | 18'h1_0000;
      step(ld, we, d);
      if (i == 500) do_reset();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule